// File: doc/BRIEF.md
# Banked Internal Data Memory

This block is the 256-byte internal scratch memory of a small 8-bit controller core. The lower half, addresses 00h to 7Fh, is a single store that every access reaches. The upper half, 80h to FFh, is overlaid on a special-function-register window. Those addresses name two physically separate things: a 128-byte RAM bank and whatever registers sit on an external SFR port.

Each access carries an addressing-mode flag from the core. An indirect access is one made through a pointer register, and stack pushes and pops count as indirect. An indirect access to the upper half lands in the upper RAM bank, so the stack may grow into it. A direct access to the same upper address is sent out on the SFR port, and the RAM is left alone. For example, a direct write to A0h updates the register at A0h. An indirect write through a pointer holding A0h updates RAM byte A0h.

Reads are synchronous with one cycle of latency. The read-data multiplexer follows the space chosen when the read was issued.

Top module: `banked_dmem`

## Requirements
- R1: An access to 00h–7Fh reaches the lower RAM whatever the mode flag says. A byte written in one mode reads back in the other mode, and the SFR strobes stay low.
- R2: A direct access (`acc_indirect`=0) to 80h–FFh raises `sfr_wr` or `sfr_rd` in the same cycle as the request. `sfr_addr` equals `acc_addr` and `sfr_wdata` equals `acc_wdata`.
- R3: An indirect access (`acc_indirect`=1) to 80h–FFh reaches the upper RAM byte at that address and raises no SFR strobe.
- R4: A direct write to an address of 80h or above leaves the upper RAM byte at that address unchanged, as a later indirect read shows.
- R5: `rd_valid` is high in exactly the cycle after a cycle with `acc_rd` high. RAM read data is presented in that same cycle.
- R6: A direct read of 80h–FFh returns on `rd_data`, one cycle later, the value the SFR port drives on `sfr_rdata` in that cycle.
- R7: The SFR strobes are high only in a cycle whose own request selects the SFR space. In an idle cycle both strobes are low.
- R8: A read and a write to the same RAM address in the same cycle return the contents held before the write. The write takes effect for later reads.
- R9: While `rst_n` is low at a clock edge, `rd_valid` is cleared. The RAM contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 8 | Access address |
| acc_indirect | input | 1 | 1 = indirect (pointer or stack) access, 0 = direct access |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | High one cycle after a read request |
| sfr_addr | output | 8 | Address presented to the SFR port |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, returned by the port one cycle after sfr_rd |

## Verification
The bench fills all 256 bytes through pointer accesses, overwrites the whole SFR window by direct access, and then reads everything back. A wrong routing decision therefore shows in one of two ways. It shows at the SFR strobes in the very cycle of the request. Otherwise it appears as a corrupted or missing byte on `rd_data` one cycle after the later read of that address. A stale read-space select in the output multiplexer would return a byte from the wrong space on the next read, and an off-by-one latency shows as `rd_valid` misplaced by a cycle.

// File: rtl/dmem_pkg.sv
// Package: shared types for the banked data memory.
// Assumes: exactly three target spaces exist for any access.
package dmem_pkg;
    typedef enum logic [1:0] {
        SPACE_LO  = 2'd0,
        SPACE_HI  = 2'd1,
        SPACE_SFR = 2'd2
    } space_e;
endpackage

// File: rtl/dmem_route.sv
// Module: dmem_route
// Decodes one access into a target space and per-bank strobes.
// The address MSB selects the bank. An upper-half address in direct mode goes to the SFR port instead.
// Assumes: NUM_BANKS is 2 (lower and upper half).
module dmem_route #(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  indirect,
    input  logic                  rd,
    input  logic                  wr,
    output logic [NUM_BANKS-1:0]  bank_we,
    output logic [NUM_BANKS-1:0]  bank_re,
    output logic                  sfr_rd,
    output logic                  sfr_wr,
    output dmem_pkg::space_e      space
);
    import dmem_pkg::*;

    logic upper;
    logic to_sfr;

    // Classify the access by address half and addressing mode.
    always_comb begin
        upper  = addr[ADDR_W-1];
        to_sfr = upper && !indirect;
        if (to_sfr)      space = SPACE_SFR;
        else if (upper)  space = SPACE_HI;
        else             space = SPACE_LO;
    end

    // Per-bank strobes: one bank per address half, suppressed for SFR traffic.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_sel
        always_comb begin
            bank_we[b] = wr && !to_sfr && (int'(upper) == b);
            bank_re[b] = rd && !to_sfr && (int'(upper) == b);
        end
    end

    // SFR port strobes follow the request cycle only.
    always_comb begin
        sfr_rd = rd && to_sfr;
        sfr_wr = wr && to_sfr;
    end

    // At most one destination takes a write in any cycle (R3).
    p_one_write_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_we, sfr_wr}));

    // Pointer accesses never touch the SFR port (R3).
    p_indirect_no_sfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        indirect |-> !(sfr_rd || sfr_wr));
endmodule

// File: rtl/dmem_bank.sv
// Module: dmem_bank
// One half of the data RAM with a synchronous write port and a registered read port.
// A read and write in the same cycle return the old contents.
// Assumes: storage is not reset; software initialises it.
module dmem_bank #(
    parameter int AW     = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store write data at the addressed byte.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Capture the addressed byte (pre-write value) on a read.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[addr];
    end

    // A write lands in the addressed byte by the next cycle (R1).
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(addr)] == $past(wdata));

    // A read in the write cycle sees the old contents (R8).
    p_read_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (re && we) |=> rdata == $past(mem[addr]));
endmodule

// File: rtl/dmem_rdmux.sv
// Module: dmem_rdmux
// Remembers which space a read targeted and steers that space's data to the output one cycle later.
// Assumes: the SFR port returns data in the cycle after its read strobe.
module dmem_rdmux #(
    parameter int DATA_W    = 8,
    parameter int NUM_BANKS = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd,
    input  dmem_pkg::space_e                  space,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_data,
    input  logic [DATA_W-1:0]                 sfr_rdata,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              rd_valid
);
    import dmem_pkg::*;

    space_e space_q;

    // Track the read space and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            space_q  <= SPACE_LO;
        end else begin
            rd_valid <= rd;
            if (rd) space_q <= space;
        end
    end

    // Output select follows the space latched with the read.
    always_comb begin
        case (space_q)
            SPACE_SFR: rd_data = sfr_rdata;
            SPACE_HI:  rd_data = bank_data[1];
            default:   rd_data = bank_data[0];
        endcase
    end

    // An SFR-space read presents the port data (R6).
    p_sfr_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && space == SPACE_SFR) |=> rd_data == sfr_rdata);
endmodule

// File: rtl/banked_dmem.sv
// Module: banked_dmem (top)
// 256-byte internal data memory whose upper half overlays an SFR window.
// A direct access to the upper half goes to the SFR port. An indirect access there goes to the upper RAM bank.
// Assumes: one access per cycle; the SFR port answers reads one cycle late.
module banked_dmem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_indirect,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic              sfr_rd,
    output logic              sfr_wr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);
    import dmem_pkg::*;

    localparam int NUM_BANKS = 2;
    localparam int BANK_AW   = ADDR_W - 1;

    logic [NUM_BANKS-1:0]             bank_we;
    logic [NUM_BANKS-1:0]             bank_re;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data;
    space_e                           space;

    dmem_route #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (acc_addr),
        .indirect (acc_indirect),
        .rd       (acc_rd),
        .wr       (acc_wr),
        .bank_we  (bank_we),
        .bank_re  (bank_re),
        .sfr_rd   (sfr_rd),
        .sfr_wr   (sfr_wr),
        .space    (space)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dmem_bank #(.AW(BANK_AW), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[b]),
            .re    (bank_re[b]),
            .addr  (acc_addr[BANK_AW-1:0]),
            .wdata (acc_wdata),
            .rdata (bank_data[b])
        );
    end

    dmem_rdmux #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (acc_rd),
        .space     (space),
        .bank_data (bank_data),
        .sfr_rdata (sfr_rdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // SFR address and data are forwarded unchanged.
    always_comb begin
        sfr_addr  = acc_addr;
        sfr_wdata = acc_wdata;
    end

    // A read request yields valid data the next cycle (R5).
    p_read_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid);

    // No request, no valid data (R5).
    p_no_spurious_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !rd_valid);

    // A direct upper-half write reaches the SFR port (R2).
    p_direct_upper_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !acc_indirect && acc_addr[ADDR_W-1]) |-> sfr_wr);

    // An idle cycle drives no SFR strobe (R7).
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_rd || acc_wr) |-> !(sfr_rd || sfr_wr));

    // Lower-half accesses never leave the block (R1).
    p_lower_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_addr[ADDR_W-1] |-> !(sfr_rd || sfr_wr));
endmodule

// File: tb/banked_dmem_test.sv
module banked_dmem_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] acc_addr;
    logic       acc_indirect, acc_rd, acc_wr;
    logic [7:0] acc_wdata;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [7:0] sfr_addr;
    logic       sfr_rd, sfr_wr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] sfr_model [128];
    logic [7:0] got;
    logic       gotv;

    always #10 clk = ~clk;

    banked_dmem uut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_indirect(acc_indirect),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .sfr_addr(sfr_addr),
        .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // Simple SFR port model: synchronous write and one-cycle read.
    always @(posedge clk) begin
        if (sfr_wr) sfr_model[sfr_addr[6:0]] <= sfr_wdata;
        if (sfr_rd) sfr_rdata <= sfr_model[sfr_addr[6:0]];
    end

    function automatic logic [7:0] ptr_pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at a falling edge, check the strobes, then return to idle and capture the read result.
    task automatic access(input logic [7:0] a, input logic ind, input logic r, input logic w,
                          input logic [7:0] d);
        logic to_sfr;
        to_sfr = a[7] && !ind;
        @(negedge clk);
        acc_addr = a; acc_indirect = ind; acc_rd = r; acc_wr = w; acc_wdata = d;
        #1;
        if (to_sfr) begin
            chk("R2 sfr_wr", {15'd0, sfr_wr}, {15'd0, w});
            chk("R2 sfr_rd", {15'd0, sfr_rd}, {15'd0, r});
            if (w) chk("R2 sfr addr/data", {sfr_addr, sfr_wdata}, {a, d});
        end else if (a[7]) begin
            chk("R3 no strobe", {14'd0, sfr_rd, sfr_wr}, 16'd0);
        end else begin
            chk("R1 no strobe", {14'd0, sfr_rd, sfr_wr}, 16'd0);
        end
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0;
        #1;
        got  = rd_data;
        gotv = rd_valid;
        chk("R7 idle strobes", {14'd0, sfr_rd, sfr_wr}, 16'd0);
        chk("R5 rd_valid", {15'd0, gotv}, {15'd0, r});
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_addr = 8'h00; acc_indirect = 1'b0;
        acc_rd = 1'b0; acc_wr = 1'b0; acc_wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset rd_valid", {15'd0, rd_valid}, 16'd0);
        chk("R9 reset strobes", {14'd0, sfr_rd, sfr_wr}, 16'd0);
        rst_n = 1'b1;

        // Fill every byte by pointer access (R1, R3).
        for (int a = 0; a < 256; a++) access(8'(a), 1'b1, 1'b0, 1'b1, ptr_pat(a));

        // Direct writes to the SFR window (R2, R4).
        for (int a = 128; a < 256; a++) access(8'(a), 1'b0, 1'b0, 1'b1, ~8'(a));

        // Pointer reads: every RAM byte still holds its pattern (R3, R4, R5).
        for (int a = 0; a < 256; a++) begin
            access(8'(a), 1'b1, 1'b1, 1'b0, 8'h00);
            chk(a >= 128 ? "R4 upper RAM kept" : "R1 lower RAM", {8'd0, got}, {8'd0, ptr_pat(a)});
        end

        // Direct writes to the lower half, read back by pointer (R1).
        for (int a = 0; a < 128; a++) access(8'(a), 1'b0, 1'b0, 1'b1, 8'(a) ^ 8'hC3);
        for (int a = 0; a < 128; a++) begin
            access(8'(a), 1'b1, 1'b1, 1'b0, 8'h00);
            chk("R1 cross-mode", {8'd0, got}, {8'd0, 8'(a) ^ 8'hC3});
        end

        // Direct reads of the SFR window return the port data (R6).
        for (int a = 128; a < 256; a++) begin
            access(8'(a), 1'b0, 1'b1, 1'b0, 8'h00);
            chk("R6 sfr read", {8'd0, got}, {8'd0, ~8'(a)});
        end

        // The A0h example: a direct write and a pointer write stay apart (R3, R4).
        access(8'hA0, 1'b0, 1'b0, 1'b1, 8'h11);
        access(8'hA0, 1'b1, 1'b0, 1'b1, 8'h22);
        access(8'hA0, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R4 A0h sfr", {8'd0, got}, 16'h0011);
        access(8'hA0, 1'b1, 1'b1, 1'b0, 8'h00);
        chk("R3 A0h ram", {8'd0, got}, 16'h0022);

        // Read and write together: old value first, new value after (R8).
        access(8'h40, 1'b1, 1'b1, 1'b1, 8'h99);
        chk("R8 old value", {8'd0, got}, {8'd0, 8'h40 ^ 8'hC3});
        access(8'h40, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R8 new value", {8'd0, got}, 16'h0099);
        access(8'hF0, 1'b1, 1'b1, 1'b1, 8'h5A);
        chk("R8 upper old", {8'd0, got}, {8'd0, ptr_pat(240)});

        // Reset again mid-run: rd_valid clears (R9).
        @(negedge clk);
        acc_rd = 1'b1; acc_indirect = 1'b1; acc_addr = 8'h10;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset clears valid", {15'd0, rd_valid}, 16'd0);
        acc_rd = 1'b0; rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule